// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of one burst access inside a synchronous DRAM. A start request brings in four values: the first column, a 3-bit burst-length code, a burst-type bit and, by implication, the wrap rules. One clock later the first column appears on the output together with a valid strobe. After that the block steps to the next column on every clock. It stops when the programmed number of beats has gone out or when a terminate request arrives.

Two orderings are available. In sequential order the low column bits count upward and wrap inside an aligned block whose size is the burst length. In interleaved order the low bits on beat k are the starting low bits XOR k. A full-page mode steps through all columns of the page, wraps from the top column to column zero, and runs until it is terminated. The mode settings are plain inputs. Command decoding, row handling and the data path belong to neighbouring logic.

Top module: `burst_col_seq`

## Requirements
- R1: The clock edge that samples `start_i` high loads the burst. From that edge on, `col_o` equals the sampled `start_col_i` and `col_vld_o` is high.
- R2: With `ileave_i`=0 and a length code of 2, 4 or 8 beats, the low log2(length) bits of the column increase by one on each beat and wrap to zero at the block boundary. The higher bits keep their starting value.
- R3: With `ileave_i`=1 and a length code of 2, 4 or 8 beats, beat k carries the starting low log2(length) bits XOR k. The higher bits keep their starting value.
- R4: The length codes are 000=1, 001=2, 010=4 and 011=8 beats. A burst of N beats raises `col_vld_o` for exactly N cycles. `last_o` is high only on the N-th beat, and `col_vld_o` falls on the following cycle unless a new start arrives.
- R5: Length code 111 selects full page. The column goes up by one on every beat modulo 2^COL_W, so 255 is followed by 0. `last_o` stays low, and the burst continues until it is terminated.
- R6: When `term_i` is sampled high during a burst and `start_i` is low, `col_vld_o` and `last_o` are low from that edge on.
- R7: When `start_i` is sampled high during a burst, the old burst is dropped and the new one begins at that edge, as in R1. This also holds when `term_i` is high in the same cycle.
- R8: The reserved length codes 100, 101 and 110 run a single-beat burst. `cfg_err_o` is high from the loading edge until the next start.
- R9: Full page together with `ileave_i`=1 runs a sequential full-page burst and raises `cfg_err_o` in the same way as R8. Every valid combination leaves `cfg_err_o` low.
- R10: During and after reset, `col_vld_o`, `last_o` and `cfg_err_o` are low and `col_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst (has priority over terminate) |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ileave_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Current column address |
| col_vld_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Unsupported length/type combination in the current burst |

## Verification
A start request can land in the same cycle as a terminate request, and it can also land on the final beat of a fixed-length burst. Both coincidences decide whether the next cycle shows a fresh first beat or an idle output. The bench forces both on purpose. It restarts a burst in the middle with `term_i` held high alongside `start_i`, and it lets random bursts end through length, terminate or restart at random beats. After every edge it compares the column, valid, last and error outputs against a model of the ordering rules.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [2:0] {
      BLEN_1    = 3'b000,
      BLEN_2    = 3'b001,
      BLEN_4    = 3'b010,
      BLEN_8    = 3'b011,
      BLEN_PAGE = 3'b111
   } blen_e;

   localparam int unsigned LEN_CODE_W = 3;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
   import bcs_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   input  logic                  ileave_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  page_o,
   output logic                  ileave_o,
   output logic                  err_o
);
   generate
      if (COL_W < 3) begin : g_bad_width
         $error("bcs_len_decode: COL_W must hold an 8-beat block");
      end
   endgenerate

   logic reserved;

   always_comb begin
      mask_o   = '0;
      page_o   = 1'b0;
      reserved = 1'b0;
      case (blen_e'(code_i))
         BLEN_1:    mask_o = '0;
         BLEN_2:    mask_o = COL_W'(1);
         BLEN_4:    mask_o = COL_W'(3);
         BLEN_8:    mask_o = COL_W'(7);
         BLEN_PAGE: begin
            mask_o = '1;
            page_o = 1'b1;
         end
         default:   reserved = 1'b1;
      endcase
      ileave_o = ileave_i & ~page_o;
      err_o    = reserved | (page_o & ileave_i);
   end
endmodule

// File: rtl/bcs_col_step.sv
module bcs_col_step #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] col_i,
   input  logic [COL_W-1:0] seed_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ileave_i,
   output logic [COL_W-1:0] nxt_o
);
   logic [COL_W-1:0] inc;
   logic [COL_W-1:0] beat_nxt;

   assign inc      = col_i + COL_W'(1);
   assign beat_nxt = beat_i + COL_W'(1);

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      always_comb begin
         if (!mask_i[i])
            nxt_o[i] = col_i[i];
         else if (ileave_i)
            nxt_o[i] = seed_i[i] ^ beat_nxt[i];
         else
            nxt_o[i] = inc[i];
      end
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ileave_i,
   input  logic                  term_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  col_vld_o,
   output logic                  last_o,
   output logic                  cfg_err_o
);
   logic [COL_W-1:0] dec_mask;
   logic             dec_page, dec_il, dec_err;

   logic [COL_W-1:0] col_q, seed_q, beat_q, mask_q, col_nxt;
   logic             page_q, il_q, vld_q, err_q;

   bcs_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i   (len_code_i),
      .ileave_i (ileave_i),
      .mask_o   (dec_mask),
      .page_o   (dec_page),
      .ileave_o (dec_il),
      .err_o    (dec_err)
   );

   bcs_col_step #(.COL_W(COL_W)) u_step (
      .col_i    (col_q),
      .seed_i   (seed_q),
      .beat_i   (beat_q),
      .mask_i   (mask_q),
      .ileave_i (il_q),
      .nxt_o    (col_nxt)
   );

   logic at_end;
   assign at_end = vld_q & ~page_q & (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         seed_q <= '0;
         beat_q <= '0;
         mask_q <= '0;
         page_q <= 1'b0;
         il_q   <= 1'b0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (start_i) begin
         col_q  <= start_col_i;
         seed_q <= start_col_i;
         beat_q <= '0;
         mask_q <= dec_mask;
         page_q <= dec_page;
         il_q   <= dec_il;
         vld_q  <= 1'b1;
         err_q  <= dec_err;
      end else if (vld_q) begin
         if (term_i || at_end) begin
            vld_q <= 1'b0;
         end else begin
            col_q  <= col_nxt;
            beat_q <= beat_q + COL_W'(1);
         end
      end
   end

   assign col_o     = col_q;
   assign col_vld_o = vld_q;
   assign last_o    = at_end;
   assign cfg_err_o = err_q;

   a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (col_vld_o && col_o == $past(start_col_i)));

   a_r6_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && term_i) |=> (!col_vld_o && !last_o));

   a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !col_vld_o);

   a_r2_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld_o && !last_o && !start_i && !term_i) |=>
         (col_vld_o && ((col_o ^ $past(col_o)) & ~mask_q) == '0));

   a_r8_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i[2] && !(&len_code_i)) |=> (cfg_err_o && last_o));

   a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (&len_code_i)) |=> !last_o);
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ileave_i = 1'b0;
   logic       term_i = 1'b0;
   logic [7:0] col_o;
   logic       col_vld_o, last_o, cfg_err_o;

   int nvec = 0;
   int nbad = 0;

   always #2 clk = ~clk;

   burst_col_seq #(.COL_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ileave_i(ileave_i), .term_i(term_i),
      .col_o(col_o), .col_vld_o(col_vld_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // length in beats, 0 means full page
   function automatic int exp_len(input logic [2:0] code);
      case (code)
         3'b000: return 1;
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         3'b111: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic bit exp_err(input logic [2:0] code, input logic il);
      return (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && il);
   endfunction

   function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                          input logic il, input int k);
      int m, base;
      if (code == 3'b111) return 8'((int'(s) + k) % 256);
      m    = exp_len(code) - 1;
      base = int'(s) & ~m;
      if (il) return 8'(base | ((int'(s) ^ k) & m));
      return 8'(base | ((int'(s) + k) & m));
   endfunction

   task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic il);
      start_i     = 1'b1;
      start_col_i = s;
      len_code_i  = code;
      ileave_i    = il;
   endtask

   // Called at the negedge on which start was issued.
   task automatic follow(input logic [7:0] s, input logic [2:0] code, input logic il,
                         input int stop_at, input bit restart,
                         input logic [7:0] ns, input logic [2:0] ncode, input logic nil);
      int  n;
      bit  xl;
      n = exp_len(code);
      @(negedge clk);
      start_i = 1'b0;
      term_i  = 1'b0;
      for (int k = 0; k < 100000; k++) begin
         xl = (n != 0) && (k == n - 1);
         chk(col_vld_o == 1'b1, "R1/R4 valid during burst", int'(col_vld_o), 1);
         if (code == 3'b111)
            chk(col_o == exp_col(s, code, il, k), "R5 page order", int'(col_o), int'(exp_col(s, code, il, k)));
         else if (il && n > 1)
            chk(col_o == exp_col(s, code, il, k), "R3 interleave order", int'(col_o), int'(exp_col(s, code, il, k)));
         else
            chk(col_o == exp_col(s, code, il, k), "R2 sequential order", int'(col_o), int'(exp_col(s, code, il, k)));
         chk(last_o == xl, "R4 last flag", int'(last_o), int'(xl));
         chk(cfg_err_o == exp_err(code, il), "R8/R9 error flag", int'(cfg_err_o), int'(exp_err(code, il)));
         if (k == stop_at && restart) begin
            issue(ns, ncode, nil);
            term_i = 1'b1;   // R7: start wins over terminate
            return;
         end
         if (k == stop_at) begin
            term_i = 1'b1;
            @(negedge clk);
            term_i = 1'b0;
            chk(!col_vld_o && !last_o, "R6 terminate stops", int'(col_vld_o), 0);
            return;
         end
         if (xl) begin
            @(negedge clk);
            chk(!col_vld_o, "R4 valid drops after last", int'(col_vld_o), 0);
            return;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog R4: run hung, got %0d expected 0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      logic [7:0] s, ns;
      logic [2:0] code, ncode;
      logic       il, nil;
      int         stop_at;
      bit         rs;
      void'($urandom(32'h1234_abcd));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!col_vld_o && !last_o && !cfg_err_o && col_o == 8'h00, "R10 reset state",
          int'({col_vld_o, last_o, cfg_err_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!col_vld_o && !last_o && !cfg_err_o, "R10 idle after reset", int'(col_vld_o), 0);

      // directed corner cases
      issue(8'h05, 3'b011, 1'b0); follow(8'h05, 3'b011, 1'b0, 1000, 0, 0, 0, 0); // R2
      issue(8'h05, 3'b011, 1'b1); follow(8'h05, 3'b011, 1'b1, 1000, 0, 0, 0, 0); // R3
      issue(8'h81, 3'b001, 1'b1); follow(8'h81, 3'b001, 1'b1, 1000, 0, 0, 0, 0); // R3
      issue(8'h4E, 3'b010, 1'b0); follow(8'h4E, 3'b010, 1'b0, 1000, 0, 0, 0, 0); // R2
      issue(8'hA7, 3'b000, 1'b1); follow(8'hA7, 3'b000, 1'b1, 1000, 0, 0, 0, 0); // R4
      issue(8'hFA, 3'b111, 1'b0); follow(8'hFA, 3'b111, 1'b0, 12, 0, 0, 0, 0);   // R5 wrap
      issue(8'h03, 3'b111, 1'b1); follow(8'h03, 3'b111, 1'b1, 5, 0, 0, 0, 0);    // R9
      issue(8'h33, 3'b101, 1'b0); follow(8'h33, 3'b101, 1'b0, 1000, 0, 0, 0, 0); // R8
      issue(8'h10, 3'b011, 1'b0); follow(8'h10, 3'b011, 1'b0, 0, 0, 0, 0, 0);    // R6 beat 0
      // R7 restart mid burst with terminate in the same cycle
      issue(8'h20, 3'b011, 1'b1);
      follow(8'h20, 3'b011, 1'b1, 3, 1, 8'h6D, 3'b010, 1'b0);
      follow(8'h6D, 3'b010, 1'b0, 1000, 0, 0, 0, 0);
      // R7 restart on the last beat
      issue(8'h08, 3'b001, 1'b0);
      follow(8'h08, 3'b001, 1'b0, 1, 1, 8'hC2, 3'b100, 1'b1);
      follow(8'hC2, 3'b100, 1'b1, 1000, 0, 0, 0, 0);

      // constrained random
      s = 8'($urandom); code = 3'($urandom); il = 1'($urandom);
      issue(s, code, il);
      for (int i = 0; i < 300; i++) begin
         if (code == 3'b111) stop_at = int'($urandom_range(0, 300));
         else if ($urandom % 3 == 0) stop_at = int'($urandom_range(0, 7));
         else stop_at = 1000;
         rs    = ($urandom % 4 == 0);
         ns    = 8'($urandom);
         ncode = 3'($urandom);
         nil   = 1'($urandom);
         follow(s, code, il, stop_at, rs, ns, ncode, nil);
         if (!(rs && (stop_at < exp_len(code) || code == 3'b111))) begin
            // no restart happened: new burst from idle
            if ($urandom % 2 == 0) @(negedge clk);
            issue(ns, ncode, nil);
         end
         s = ns; code = ncode; il = nil;
      end
      follow(s, code, il, 20, 0, 0, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule